// File: doc/BRIEF.md
# VLAN Tagged Frame Detector

This block observes a received Ethernet frame as a byte stream that starts at the first destination-address byte (no preamble) and runs through the final CRC byte. For each frame it decides whether the frame carries an IEEE 802.1Q tag whose 16-bit tag field equals a programmed value. It also applies the maximum legal length that fits the frame: 1518 bytes for an ordinary frame, 1522 bytes for a matched tagged frame. It raises an oversize flag when the frame is longer than that limit.

Results appear in the cycle after the last byte of a frame, as a one-cycle valid pulse together with the match flag, the oversize flag and the byte count. These fields hold their values until the first byte of the next frame arrives, and are cleared after that byte. The tag value is written through a simple write strobe. A write takes effect only while no frame is in progress.

Top module: `vlan_frame_detector`

## Requirements
- R1: After reset, stat_valid, stat_vlan, stat_oversize and stat_len are zero, and the programmed tag is 0x0000.
- R2: In the cycle after the byte carrying in_eof is accepted (in_valid high), stat_valid is high for exactly one cycle. In that cycle stat_len equals the number of accepted bytes from the in_sof byte through the in_eof byte, inclusive. Cycles with in_valid low add nothing to the count.
- R3: stat_vlan is set when bytes 13 and 14 of the frame (counting from 1, byte 13 the high byte) equal 0x8100, and bytes 15 and 16 (byte 15 the high byte) equal the programmed tag.
- R4: When bytes 13 and 14 differ from 0x8100, stat_vlan stays clear even if bytes 15 and 16 equal the programmed tag.
- R5: A frame that ends before its 16th byte is never reported as tagged. A matching frame of exactly 16 bytes is reported as tagged.
- R6: For a frame without a tag match, stat_oversize is set exactly when stat_len exceeds 1518.
- R7: For a frame with a tag match, stat_oversize is set exactly when stat_len exceeds 1522.
- R8: A tag write is ignored when it arrives in the cycle of an accepted in_sof byte, or at any time from that byte through the in_eof byte of the same frame. A write outside a frame takes effect for the next frame.
- R9: stat_vlan, stat_oversize and stat_len keep their values after the valid pulse. In the cycle after the next accepted in_sof byte they read zero, unless that byte also carries in_eof.
- R10: An in_sof byte that arrives while a frame is open starts a new frame. The count restarts at 1, and the tag check restarts at byte 13 of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tag_wr_en | input | 1 | Strobe that writes the programmed tag |
| tag_wr_data | input | 16 | New tag value |
| in_valid | input | 1 | A frame byte is present on in_data |
| in_sof | input | 1 | The present byte is the first of a frame |
| in_eof | input | 1 | The present byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| stat_valid | output | 1 | One-cycle pulse: frame status is ready |
| stat_vlan | output | 1 | Frame matched the tag type and the programmed tag |
| stat_oversize | output | 1 | Frame longer than its legal maximum |
| stat_len | output | 16 | Byte count of the frame, CRC included |

## Verification
Two of the block's functions can fall in the same cycle. The first is the tag decision at byte 16, which sets the length limit. The second is the end-of-frame status update, which compares the length with that limit. The bench provokes this with 16-byte frames that end on the tag byte itself, and with frames of 1522 and 1523 bytes whose limit depends on the match.

A second collision also arises. A tag write can coincide with a frame's start or end byte, and a start byte can coincide with an end byte. The bench judges each of these cycles against a behavioural model that updates the tag and the status in the order the requirements fix.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam logic [15:0] TPID_8021Q = 16'h8100;
  localparam int TYPE_HI_POS = 13;
  localparam int TYPE_LO_POS = 14;
  localparam int TAG_HI_POS  = 15;
  localparam int TAG_LO_POS  = 16;
endpackage

// File: rtl/vfd_tag_reg.sv
module vfd_tag_reg #(
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             busy,
  input  logic [TAG_W-1:0] wr_data,
  output logic [TAG_W-1:0] tag
);
  always_ff @(posedge clk) begin
    if (rst) tag <= '0;
    else if (wr_en && !busy) tag <= wr_data;
  end
endmodule

// File: rtl/vfd_byte_counter.sv
module vfd_byte_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             sof,
  output logic [LEN_W-1:0] idx
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;
  logic [LEN_W-1:0] cnt_q;

  // 1-based position of the byte currently on the bus
  always_comb begin
    if (sof)                 idx = LEN_W'(1);
    else if (cnt_q == CNT_MAX) idx = cnt_q;
    else                     idx = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (valid) cnt_q <= idx;
  end
endmodule

// File: rtl/vfd_tag_matcher.sv
module vfd_tag_matcher #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             sof,
  input  logic [7:0]       data,
  input  logic [LEN_W-1:0] idx,
  input  logic [15:0]      tag,
  output logic             hit_now
);
  import vfd_pkg::*;
  logic [7:0] type_hi_q, tag_hi_q;
  logic       type_ok_q, hit_q;
  logic       at_tag_lo;

  assign at_tag_lo = valid && (idx == LEN_W'(TAG_LO_POS));

  // decision including the byte present this cycle
  always_comb begin
    if (valid && sof)   hit_now = 1'b0;
    else if (at_tag_lo) hit_now = type_ok_q && ({tag_hi_q, data} == tag);
    else                hit_now = hit_q;
  end

  always_ff @(posedge clk) begin
    if (rst || (valid && sof)) begin
      type_hi_q <= '0;
      tag_hi_q  <= '0;
      type_ok_q <= 1'b0;
      hit_q     <= 1'b0;
    end else if (valid) begin
      if (idx == LEN_W'(TYPE_HI_POS)) type_hi_q <= data;
      if (idx == LEN_W'(TYPE_LO_POS)) type_ok_q <= ({type_hi_q, data} == TPID_8021Q);
      if (idx == LEN_W'(TAG_HI_POS))  tag_hi_q  <= data;
      if (at_tag_lo)                  hit_q     <= hit_now;
    end
  end
endmodule

// File: rtl/vlan_frame_detector.sv
module vlan_frame_detector #(
  parameter int LEN_W     = 16,
  parameter int BASE_MAX  = 1518,
  parameter int TAG_EXTRA = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tag_wr_en,
  input  logic [15:0]      tag_wr_data,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  output logic             stat_valid,
  output logic             stat_vlan,
  output logic             stat_oversize,
  output logic [LEN_W-1:0] stat_len
);
  localparam logic [LEN_W-1:0] PLAIN_LIMIT  = LEN_W'(BASE_MAX);
  localparam logic [LEN_W-1:0] TAGGED_LIMIT = LEN_W'(BASE_MAX + TAG_EXTRA);

  logic             in_frame_q;
  logic             busy;
  logic [15:0]      tag_q;
  logic [LEN_W-1:0] idx;
  logic             hit_now;
  logic [LEN_W-1:0] limit;

  assign busy  = in_frame_q || (in_valid && in_sof);
  assign limit = hit_now ? TAGGED_LIMIT : PLAIN_LIMIT;

  vfd_tag_reg #(.TAG_W(16)) u_tag (
    .clk(clk), .rst(rst), .wr_en(tag_wr_en), .busy(busy),
    .wr_data(tag_wr_data), .tag(tag_q)
  );

  vfd_byte_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .valid(in_valid), .sof(in_sof), .idx(idx)
  );

  vfd_tag_matcher #(.LEN_W(LEN_W)) u_match (
    .clk(clk), .rst(rst), .valid(in_valid), .sof(in_sof), .data(in_data),
    .idx(idx), .tag(tag_q), .hit_now(hit_now)
  );

  always_ff @(posedge clk) begin
    if (rst) in_frame_q <= 1'b0;
    else if (in_valid && in_eof) in_frame_q <= 1'b0;
    else if (in_valid && in_sof) in_frame_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid    <= 1'b0;
      stat_vlan     <= 1'b0;
      stat_oversize <= 1'b0;
      stat_len      <= '0;
    end else if (in_valid && in_eof) begin
      stat_valid    <= 1'b1;
      stat_vlan     <= hit_now;
      stat_oversize <= idx > limit;
      stat_len      <= idx;
    end else begin
      stat_valid <= 1'b0;
      if (in_valid && in_sof) begin
        stat_vlan     <= 1'b0;
        stat_oversize <= 1'b0;
        stat_len      <= '0;
      end
    end
  end
endmodule

// File: rtl/vfd_checker.sv
module vfd_checker #(
  parameter int LEN_W     = 16,
  parameter int BASE_MAX  = 1518,
  parameter int TAG_EXTRA = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eof,
  input logic             busy,
  input logic [15:0]      tag_q,
  input logic             stat_valid,
  input logic             stat_vlan,
  input logic             stat_oversize,
  input logic [LEN_W-1:0] stat_len
);
  AST_PULSE_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> $past(in_valid && in_eof)); // R2
  AST_VLAN_NEEDS_16: assert property (@(posedge clk) disable iff (rst)
    stat_valid && stat_vlan |-> stat_len >= LEN_W'(16)); // R5
  AST_SHORT_NOT_OVER: assert property (@(posedge clk) disable iff (rst)
    stat_valid && stat_len <= LEN_W'(BASE_MAX) |-> !stat_oversize); // R6
  AST_LONG_IS_OVER: assert property (@(posedge clk) disable iff (rst)
    stat_valid && stat_len > LEN_W'(BASE_MAX + TAG_EXTRA) |-> stat_oversize); // R7
  AST_TAG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(tag_q)); // R8
  AST_CLEAR_ON_SOF: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sof && !in_eof |=> !stat_vlan && !stat_oversize && stat_len == '0); // R9
endmodule

bind vlan_frame_detector vfd_checker #(
  .LEN_W(LEN_W), .BASE_MAX(BASE_MAX), .TAG_EXTRA(TAG_EXTRA)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
  .busy(busy), .tag_q(tag_q), .stat_valid(stat_valid), .stat_vlan(stat_vlan),
  .stat_oversize(stat_oversize), .stat_len(stat_len)
);

// File: tb/vlan_frame_detector_tb.sv
module vlan_frame_detector_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tag_wr_en = 1'b0;
  logic [15:0] tag_wr_data = '0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        stat_valid, stat_vlan, stat_oversize;
  logic [15:0] stat_len;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  vlan_frame_detector u_dut (
    .clk(clk), .rst(rst), .tag_wr_en(tag_wr_en), .tag_wr_data(tag_wr_data),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .stat_valid(stat_valid), .stat_vlan(stat_vlan),
    .stat_oversize(stat_oversize), .stat_len(stat_len)
  );

  // behavioural reference model
  logic [7:0]  m_q[$];
  logic [15:0] m_tag = '0;
  bit          m_open = 0;
  bit          m_valid = 0, m_vlan = 0, m_over = 0;
  int          m_len = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete(); m_tag = '0; m_open = 0;
      m_valid = 0; m_vlan = 0; m_over = 0; m_len = 0;
    end else begin
      bit busy_now;
      busy_now = m_open || (in_valid && in_sof);
      if (tag_wr_en && !busy_now) m_tag = tag_wr_data;
      m_valid = 0;
      if (in_valid) begin
        if (in_sof) begin m_q.delete(); m_open = 1; end
        m_q.push_back(in_data);
        if (in_eof) begin
          m_len   = m_q.size();
          m_vlan  = (m_len >= 16) && ({m_q[12], m_q[13]} == 16'h8100)
                    && ({m_q[14], m_q[15]} == m_tag);
          m_over  = m_len > (m_vlan ? 1522 : 1518);
          m_valid = 1;
          m_open  = 0;
        end else if (in_sof) begin
          m_vlan = 0; m_over = 0; m_len = 0;
        end
      end
    end
    #1;
    if (!rst) begin
      check("R2 valid", stat_valid, m_valid);
      check("R2 len", stat_len, m_len);
      check("R3 vlan", stat_vlan, m_vlan);
      check("R6 oversize", stat_oversize, m_over);
    end
  end

  task automatic write_tag(logic [15:0] v);
    @(negedge clk); tag_wr_en = 1'b1; tag_wr_data = v;
    @(negedge clk); tag_wr_en = 1'b0;
  endtask

  // one byte per call, driven at the falling edge
  task automatic put(bit sof, bit eof, logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_eof = eof; in_data = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    end
  endtask

  function automatic logic [7:0] fbyte(int pos, logic [15:0] ty, logic [15:0] tg);
    case (pos)
      13: return ty[15:8];
      14: return ty[7:0];
      15: return tg[15:8];
      16: return tg[7:0];
      default: return 8'(pos * 7 + 3);
    endcase
  endfunction

  // sends a full frame; optional bubbles and an optional mid-frame tag write
  task automatic send(int len, logic [15:0] ty, logic [15:0] tg, bit bubbles,
                      bit wr_mid, logic [15:0] wr_val);
    for (int p = 1; p <= len; p++) begin
      put(p == 1, p == len, fbyte(p, ty, tg));
      tag_wr_en = wr_mid && (p == 1 || p == 5 || p == len);
      tag_wr_data = wr_val;
      if (bubbles && (p % 5 == 0) && p != len) begin
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; tag_wr_en = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; tag_wr_en = 1'b0;
  endtask

  task automatic expect_frame(string req, int len, bit vl, bit ov);
    check({req, " pulse"}, stat_valid, 1);
    check({req, " len"}, stat_len, len);
    check({req, " vlan"}, stat_vlan, vl);
    check({req, " over"}, stat_oversize, ov);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid", stat_valid, 0);
    check("R1 vlan", stat_vlan, 0);
    check("R1 over", stat_oversize, 0);
    check("R1 len", stat_len, 0);
    // R1: reset tag is zero, so a frame with tag 0x0000 matches
    send(64, 16'h8100, 16'h0000, 0, 0, 0);
    expect_frame("R1 zero tag", 64, 1, 0);

    write_tag(16'h0123);
    send(64, 16'h8100, 16'h0123, 1, 0, 0);
    expect_frame("R3 match", 64, 1, 0);
    send(64, 16'h8100, 16'h0124, 0, 0, 0);
    expect_frame("R3 tag miss", 64, 0, 0);
    send(64, 16'h0800, 16'h0123, 0, 0, 0);
    expect_frame("R4 type miss", 64, 0, 0);
    send(15, 16'h8100, 16'h0123, 0, 0, 0);
    expect_frame("R5 short", 15, 0, 0);
    send(16, 16'h8100, 16'h0123, 0, 0, 0);
    expect_frame("R5 exact16", 16, 1, 0);

    send(1518, 16'h0800, 16'h0123, 0, 0, 0);
    expect_frame("R6 1518", 1518, 0, 0);
    send(1519, 16'h0800, 16'h0123, 0, 0, 0);
    expect_frame("R6 1519", 1519, 0, 1);
    send(1522, 16'h8100, 16'h0999, 0, 0, 0);
    expect_frame("R6 1522 untagged", 1522, 0, 1);
    send(1522, 16'h8100, 16'h0123, 1, 0, 0);
    expect_frame("R7 1522", 1522, 1, 0);
    send(1523, 16'h8100, 16'h0123, 0, 0, 0);
    expect_frame("R7 1523", 1523, 1, 1);

    // R8: writes during a frame (on sof, middle, eof) are ignored
    send(40, 16'h8100, 16'h0123, 0, 1, 16'h0456);
    expect_frame("R8 during", 40, 1, 0);
    send(40, 16'h8100, 16'h0123, 0, 0, 0);
    expect_frame("R8 old tag kept", 40, 1, 0);
    write_tag(16'h0456);
    send(40, 16'h8100, 16'h0456, 0, 0, 0);
    expect_frame("R8 new tag", 40, 1, 0);

    // R9: status holds, then clears after the next sof byte
    idle(5);
    check("R9 hold valid", stat_valid, 0);
    check("R9 hold len", stat_len, 40);
    check("R9 hold vlan", stat_vlan, 1);
    put(1, 0, 8'h11);
    @(negedge clk); in_valid = 1'b0;
    check("R9 clear len", stat_len, 0);
    check("R9 clear vlan", stat_vlan, 0);

    // R10: restart mid-frame, then a tagged 20-byte frame
    for (int p = 2; p <= 9; p++) put(0, 0, 8'h81);
    for (int p = 1; p <= 20; p++) put(p == 1, p == 20, fbyte(p, 16'h8100, 16'h0456));
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    expect_frame("R10 restart", 20, 1, 0);

    // single-byte frame: sof and eof together
    put(1, 1, 8'h55);
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    expect_frame("R2 one byte", 1, 0, 0);
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule